// File: doc/BRIEF.md
# Write data response scanner

After a packetized write, the host reads a short window of bytes back from the link. This block checks that window. The window can hold a response that belongs to an earlier data packet as well as the response to the final packet. For that reason the block searches from the end of the window toward its front and keeps the latest response start byte it finds. The block then decides whether the write completed cleanly, whether the device answered with a bad response, or whether no response came back at all.

Software or a sequencer pulses `start_i` once all data has been sent. It then feeds the read-back bytes on `byte_i`, qualified by `byte_valid_i`. When the fourth byte has been taken, `done_o` pulses for one cycle. The verdict outputs then hold until the next start pulse.

Top module: `wr_resp_scanner`

## Requirements
- R1: After reset, `done_o`, `ok_o` and `err_o` are 0 and `err_code_o` is 2'b00.
- R2: After a start pulse, exactly four bytes with `byte_valid_i` high are collected, numbered 0 to 3 in arrival order. `done_o` is high for one cycle only, in the cycle after the clock edge that samples byte 3.
- R3: A byte is a response start byte when its upper nibble is 4'hC. Its lower nibble gives the packet kind: 1 for first, 2 for inner, 3 for last. Only positions 2, 1 and 0 are searched, in that order. The first match found, which is the latest start byte, is selected, and the byte after it is its status byte.
- R4: The verdict is success when the selected byte has kind 3 and its status byte equals 8'h00. Success gives `ok_o`=1, `err_o`=0 and `err_code_o`=2'b00.
- R5: A selected byte whose kind is not 3, or whose status byte is not 8'h00, gives `ok_o`=0, `err_o`=1 and `err_code_o`=2'b01 (bad response).
- R6: When none of positions 0 to 2 is a start byte, the result is `ok_o`=0, `err_o`=1 and `err_code_o`=2'b10 (missing response). Position 3 is never treated as a start byte.
- R7: The verdict outputs hold until the next start pulse. A start pulse clears them to 0 in the following cycle.
- R8: Bytes presented while no collection is armed have no effect on any output. This covers bytes before the first start and bytes after the fourth byte. A start pulse takes priority over a byte presented in the same cycle, and that byte is dropped.
- R9: Cycles with `byte_valid_i` low do not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms a new collection and clears the verdict |
| byte_valid_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Read-back byte |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| ok_o | output | 1 | Write acknowledged cleanly |
| err_o | output | 1 | Bad or missing response |
| err_code_o | output | 2 | 00 none, 01 bad response, 10 missing |

## Verification
All four results (`done_o`, `ok_o`, `err_o`, `err_code_o`) come from registers loaded on the edge that samples byte 3. They are therefore due one cycle after that byte is driven, and `done_o` drops again one cycle later. The cleared verdict appears one cycle after a start pulse. The bench drives on the falling edge and samples on the following falling edge, so every check lands exactly on the cycle in which its value is due. Idle cycles and stray bytes are placed between windows to confirm that they shift none of these timings.

// File: rtl/wr_resp_scanner.sv
module wr_resp_scanner #(
  parameter int         WIN  = 4,
  parameter int         BW   = 8,
  parameter logic [3:0] TAG  = 4'hC,
  parameter logic [3:0] LAST = 4'h3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          byte_valid_i,
  input  logic [BW-1:0] byte_i,
  output logic          done_o,
  output logic          ok_o,
  output logic          err_o,
  output logic [1:0]    err_code_o
);

  localparam int CW = $clog2(WIN + 1);
  localparam logic [1:0] CODE_BAD  = 2'b01;
  localparam logic [1:0] CODE_MISS = 2'b10;

  logic          active;
  logic [CW-1:0] cnt;
  logic [BW-1:0] hold [WIN-1];
  logic [BW-1:0] cur  [WIN];
  logic          take, last_take;
  logic          hit, good;
  logic [BW-1:0] sel_hdr, sel_sta;

  assign take      = active && byte_valid_i && !start_i;
  assign last_take = take && (cnt == CW'(WIN - 1));

  genvar gi;
  generate
    for (gi = 0; gi < WIN - 1; gi++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hold[gi] <= '0;
        else if (take && cnt == CW'(gi)) hold[gi] <= byte_i;
      assign cur[gi] = hold[gi];
    end
  endgenerate
  assign cur[WIN-1] = byte_i;

  always_comb begin
    hit     = 1'b0;
    sel_hdr = '0;
    sel_sta = '0;
    for (int p = WIN - 2; p >= 0; p--) begin
      if (!hit && cur[p][BW-1 -: 4] == TAG) begin
        hit     = 1'b1;
        sel_hdr = cur[p];
        sel_sta = cur[p+1];
      end
    end
  end

  assign good = hit && (sel_hdr[3:0] == LAST) && (sel_sta == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= 2'b00;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active     <= 1'b1;
        cnt        <= '0;
        ok_o       <= 1'b0;
        err_o      <= 1'b0;
        err_code_o <= 2'b00;
      end else if (last_take) begin
        active     <= 1'b0;
        cnt        <= '0;
        done_o     <= 1'b1;
        ok_o       <= good;
        err_o      <= !good;
        err_code_o <= good ? 2'b00 : (hit ? CODE_BAD : CODE_MISS);
      end else if (take) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wr_resp_scanner_chk.sv
module wr_resp_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       byte_valid_i,
  input logic       done_o,
  input logic       ok_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(byte_valid_i) && !$past(start_i));

  assert_verdict_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ok_o ^ err_o));

  assert_ok_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (err_code_o == 2'b00) && !err_o);

  assert_err_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o == 2'b01 || err_code_o == 2'b10));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ok_o && !err_o && !done_o && err_code_o == 2'b00);

  assert_verdict_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> done_o || ($stable(ok_o) && $stable(err_o) && $stable(err_code_o)));

endmodule

bind wr_resp_scanner wr_resp_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
  .done_o(done_o), .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/sim_wr_resp_scanner.sv
`timescale 1ns/1ps
module sim_wr_resp_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       done_o, ok_o, err_o;
  logic [1:0] err_code_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wr_resp_scanner u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .done_o(done_o), .ok_o(ok_o), .err_o(err_o),
    .err_code_o(err_code_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {done,ok,err,code}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] w [4];
    int sel;
    w[0] = b0; w[1] = b1; w[2] = b2; w[3] = b3;
    sel = -1;
    for (int p = 2; p >= 0; p--)
      if (sel < 0 && w[p][7:4] == 4'hC) sel = p;
    if (sel < 0) return 5'b1_0_1_10;
    if (w[sel][3:0] == 4'h3 && w[sel+1] == 8'h00) return 5'b1_1_0_00;
    return 5'b1_0_1_01;
  endfunction

  task automatic put(input logic [7:0] b);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
    byte_i = 8'h00;
  endtask

  initial begin
    logic [7:0] vals [6];
    logic [4:0] exp;
    logic [4:0] held;
    int idx;
    vals[0] = 8'h00; vals[1] = 8'hC3; vals[2] = 8'hC1;
    vals[3] = 8'hC2; vals[4] = 8'h3C; vals[5] = 8'hCF;

    repeat (3) @(negedge clk);
    chk("R1", {done_o, ok_o, err_o, err_code_o}, 5'b0_0_0_00);
    rst_n = 1'b1;
    @(negedge clk);

    put(8'hC3); put(8'h00); put(8'hC3); put(8'h00);
    chk("R8 bytes before start", {done_o, ok_o, err_o, err_code_o}, 5'b0_0_0_00);

    idx = 0;
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int d = 0; d < 6; d++) begin
            idx++;
            start_i = 1'b1;
            if (idx % 5 == 0) begin
              byte_valid_i = 1'b1;
              byte_i = 8'hC3;
            end
            @(negedge clk);
            start_i = 1'b0;
            byte_valid_i = 1'b0;
            chk("R7 start clears", {done_o, ok_o, err_o, err_code_o}, 5'b0_0_0_00);
            put(vals[a]);
            if (idx % 3 == 0) @(negedge clk);
            put(vals[b]);
            put(vals[c]);
            if (idx % 7 == 0) begin
              @(negedge clk);
              chk("R9 idle does not count", {done_o, ok_o, err_o, err_code_o}, 5'b0_0_0_00);
            end
            exp = model(vals[a], vals[b], vals[c], vals[d]);
            put(vals[d]);
            chk(exp[2] ? (exp[1:0] == 2'b10 ? "R6 missing" : "R5 bad") : "R4/R3 ok",
                {done_o, ok_o, err_o, err_code_o}, exp);
            held = {1'b0, exp[3:0]};
            @(negedge clk);
            chk("R2 done one cycle", {done_o, ok_o, err_o, err_code_o}, held);
            if (idx % 4 == 0) begin
              put(8'h00); put(8'hC3); put(8'h00); put(8'hC1);
              chk("R8 bytes after fourth", {done_o, ok_o, err_o, err_code_o}, held);
            end
          end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule